// File: doc/BRIEF.md
# SD Short Response Receiver

This block takes in the 48-bit short response a card returns on the command line. The response arrives one bit per card clock, most significant bit first. The host side raises `bit_en` for one system clock on each card-clock sampling point and presents the sampled line level on `cmd_in` in that cycle. The receiver waits on a high line, locks onto the first low bit as the start of a frame, and checks the frame markers. It runs a CRC7 over the header and payload and compares it with the CRC the card sent. When the frame is complete it presents the command index and the 32-bit argument.

When the index is the one used by the address-publication response (index 3 by default), the block also splits the argument into a 16-bit relative card address and a decoded status half. The `io_only` input picks how the low status bits are read. A memory card carries card-state and condition bits there. An I/O-only card marks those bits reserved, so they are reported as zero. The top three status bits mean the same thing in both modes.

The serial input has no back-pressure. A card cannot be stalled, so `bit_en` acts as a valid strobe with no ready. The results come out as a one-cycle `done` pulse, and every result output holds its value until the next pulse. The downstream logic must take the result while `done` is high or at any time before the next pulse.

Top module: `sd_resp_rx`

## Requirements
- R1: While idle, strobed bits equal to 1 are ignored, and the first strobed 0 is taken as frame bit 47 and starts capture.
- R2: `done` is high for exactly one clock, in the clock after the strobe that delivers the 48th bit, and never earlier in the frame.
- R3: On `done`, `index` equals frame bits 45..40 and `argument` equals frame bits 39..8.
- R4: The CRC7 uses generator x^7+x^3+1 with a zero initial value over frame bits 47..8. If the result differs from bits 7..1, `crc_err` is 1 with `done`; otherwise it is 0.
- R5: `frame_err` is 1 with `done` when bit 47 is not 0, bit 46 (direction) is not 0, or bit 0 (end) is not 1.
- R6: With index 3 on `done`, `rca` equals argument bits 31..16, and `st_com_crc`, `st_illegal` and `st_error` equal argument bits 15, 14 and 13 in both modes.
- R7: With index 3 and `io_only`=0, `st_state` equals argument bits 12..9, `st_ready` equals bit 8, `st_app_cmd` equals bit 5 and `st_ake_err` equals bit 3. With `io_only`=1 all four are 0.
- R8: With any index other than 3, `rca` and every `st_*` output are 0.
- R9: After reset, `done`, `crc_err`, `frame_err`, `index`, `argument`, `rca` and every `st_*` output are 0.
- R10: `cmd_in` is sampled only in cycles where `bit_en` is 1; its level in other cycles has no effect.
- R11: Between `done` pulses, all result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per card-clock sample point |
| cmd_in | input | 1 | Sampled command line level |
| io_only | input | 1 | 1: I/O-only status meaning, 0: memory-card meaning |
| done | output | 1 | One-cycle pulse when a frame is complete |
| crc_err | output | 1 | CRC7 mismatch for the last frame |
| frame_err | output | 1 | Start, direction or end bit wrong in the last frame |
| index | output | 6 | Command index field |
| argument | output | 32 | Argument field |
| rca | output | 16 | Relative card address (index 3 only) |
| st_com_crc | output | 1 | Status: previous command failed its CRC |
| st_illegal | output | 1 | Status: illegal command |
| st_error | output | 1 | Status: general error |
| st_state | output | 4 | Status: memory-card state |
| st_ready | output | 1 | Status: memory card ready for data |
| st_app_cmd | output | 1 | Status: application command expected |
| st_ake_err | output | 1 | Status: authentication sequence error |

## Verification
The bench sweeps all 64 index values in both status modes, with generated arguments. A decoder that keyed on the wrong index, or that leaked memory-card fields in I/O-only mode, would put nonzero values on the status outputs. Each CRC bit and one payload bit is flipped in turn. A CRC with the wrong polynomial, initial value or span would miss a flip or flag a clean frame. Separate frames carry a wrong direction bit or end bit, each with a CRC that is otherwise correct. These show that the framing check and the CRC check do not mask each other. Idle high strobes and inverted levels between strobes are fed in. A receiver that started on a high bit, or that sampled without a strobe, would misalign every field.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;

  // Decoded view of the address-publication status half
  typedef struct packed {
    logic [15:0] rca;
    logic        com_crc;
    logic        illegal;
    logic        gen_err;
    logic [3:0]  state;
    logic        ready;
    logic        app_cmd;
    logic        ake_err;
  } sd_stat_t;

  localparam int unsigned STAT_HALF = 16;

endpackage

// File: rtl/sd_resp_crc.sv
module sd_resp_crc #(
  parameter int unsigned         CRC_W = 7,
  parameter logic [CRC_W-1:0]    POLY  = 7'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] nxt;
  logic             fb;

  // Serial LFSR step; clr_i restarts from zero with the current bit
  always_comb begin
    base = clr_i ? '0 : crc_o;
    fb   = bit_i ^ base[CRC_W-1];
    nxt  = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_o <= '0;
    else if (en_i) crc_o <= nxt;
  end

endmodule

// File: rtl/sd_resp_status_dec.sv
module sd_resp_status_dec
  import sd_resp_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned ARG_W    = 32,
  parameter int unsigned ADDR_IDX = 3
) (
  input  logic [IDX_W-1:0] index_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             io_only_i,
  output sd_stat_t         stat_o
);

  localparam int unsigned HALF = STAT_HALF;

  logic [HALF-1:0] st;
  assign st = arg_i[HALF-1:0];

  always_comb begin
    stat_o = '0;
    if (index_i == IDX_W'(ADDR_IDX)) begin
      stat_o.rca     = arg_i[ARG_W-1 -: HALF];
      stat_o.com_crc = st[HALF-1];
      stat_o.illegal = st[HALF-2];
      stat_o.gen_err = st[HALF-3];
      if (!io_only_i) begin
        stat_o.state   = st[12:9];
        stat_o.ready   = st[8];
        stat_o.app_cmd = st[5];
        stat_o.ake_err = st[3];
      end
    end
  end

endmodule

// File: rtl/sd_resp_rx.sv
module sd_resp_rx
  import sd_resp_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 48,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned ARG_W      = 32,
  parameter int unsigned CRC_W      = 7,
  parameter int unsigned ADDR_IDX   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             cmd_in,
  input  logic             io_only,
  output logic             done,
  output logic             crc_err,
  output logic             frame_err,
  output logic [IDX_W-1:0] index,
  output logic [ARG_W-1:0] argument,
  output logic [15:0]      rca,
  output logic             st_com_crc,
  output logic             st_illegal,
  output logic             st_error,
  output logic [3:0]       st_state,
  output logic             st_ready,
  output logic             st_app_cmd,
  output logic             st_ake_err
);

  localparam int unsigned CNT_W    = $clog2(FRAME_BITS);
  localparam int unsigned CRC_SPAN = FRAME_BITS - CRC_W - 1;
  localparam int unsigned ARG_LSB  = CRC_W + 1;
  localparam int unsigned IDX_LSB  = ARG_LSB + ARG_W;
  localparam int unsigned DIR_POS  = FRAME_BITS - 2;

  logic                  busy;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-2:0] shreg;
  logic [FRAME_BITS-1:0] frame;
  logic [CRC_W-1:0]      crc_q;
  logic                  crc_en;
  logic                  last;
  logic [IDX_W-1:0]      f_idx;
  logic [ARG_W-1:0]      f_arg;
  sd_stat_t              f_stat;

  assign frame  = {shreg, cmd_in};
  assign f_idx  = frame[IDX_LSB +: IDX_W];
  assign f_arg  = frame[ARG_LSB +: ARG_W];
  assign crc_en = bit_en && (busy ? (cnt < CNT_W'(CRC_SPAN)) : !cmd_in);
  assign last   = busy && bit_en && (cnt == CNT_W'(FRAME_BITS - 1));

  sd_resp_crc #(.CRC_W(CRC_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (crc_en),
    .clr_i (!busy),
    .bit_i (cmd_in),
    .crc_o (crc_q)
  );

  sd_resp_status_dec #(.IDX_W(IDX_W), .ARG_W(ARG_W), .ADDR_IDX(ADDR_IDX)) u_dec (
    .index_i   (f_idx),
    .arg_i     (f_arg),
    .io_only_i (io_only),
    .stat_o    (f_stat)
  );

  always_ff @(posedge clk) begin
    if (bit_en) shreg <= {shreg[FRAME_BITS-3:0], cmd_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cnt        <= '0;
      done       <= 1'b0;
      crc_err    <= 1'b0;
      frame_err  <= 1'b0;
      index      <= '0;
      argument   <= '0;
      rca        <= '0;
      st_com_crc <= 1'b0;
      st_illegal <= 1'b0;
      st_error   <= 1'b0;
      st_state   <= '0;
      st_ready   <= 1'b0;
      st_app_cmd <= 1'b0;
      st_ake_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bit_en) begin
        if (!busy) begin
          if (!cmd_in) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (last) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        index      <= f_idx;
        argument   <= f_arg;
        crc_err    <= (crc_q != frame[CRC_W:1]);
        frame_err  <= frame[FRAME_BITS-1] | frame[DIR_POS] | !frame[0];
        rca        <= f_stat.rca;
        st_com_crc <= f_stat.com_crc;
        st_illegal <= f_stat.illegal;
        st_error   <= f_stat.gen_err;
        st_state   <= f_stat.state;
        st_ready   <= f_stat.ready;
        st_app_cmd <= f_stat.app_cmd;
        st_ake_err <= f_stat.ake_err;
      end
    end
  end

endmodule

// File: rtl/sd_resp_rx_chk.sv
module sd_resp_rx_chk #(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned ARG_W    = 32,
  parameter int unsigned ADDR_IDX = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             cmd_in,
  input logic             io_only,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] index,
  input logic [ARG_W-1:0] argument,
  input logic [15:0]      rca,
  input logic             st_com_crc,
  input logic             st_illegal,
  input logic             st_error,
  input logic [3:0]       st_state,
  input logic             st_ready,
  input logic             st_app_cmd,
  input logic             st_ake_err
);

  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bit_en && !cmd_in)) else $error("capture began without a low strobe"); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one cycle"); // R2

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bit_en)) else $error("done without a final strobe"); // R2

  AST_OTHER_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && index != IDX_W'(ADDR_IDX)) |-> (rca == '0 && !st_com_crc && !st_illegal &&
      !st_error && st_state == '0 && !st_ready && !st_app_cmd && !st_ake_err))
    else $error("status decoded for wrong index"); // R8

  AST_IO_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(io_only)) |-> (st_state == '0 && !st_ready && !st_app_cmd && !st_ake_err))
    else $error("reserved bits shown in io-only mode"); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(index) && $stable(argument) && $stable(rca)))
    else $error("result changed without done"); // R11

endmodule

bind sd_resp_rx sd_resp_rx_chk #(.IDX_W(IDX_W), .ARG_W(ARG_W), .ADDR_IDX(ADDR_IDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .cmd_in     (cmd_in),
  .io_only    (io_only),
  .busy       (busy),
  .done       (done),
  .index      (index),
  .argument   (argument),
  .rca        (rca),
  .st_com_crc (st_com_crc),
  .st_illegal (st_illegal),
  .st_error   (st_error),
  .st_state   (st_state),
  .st_ready   (st_ready),
  .st_app_cmd (st_app_cmd),
  .st_ake_err (st_ake_err)
);

// File: tb/sd_resp_rx_tb.sv
module sd_resp_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        cmd_in = 1'b1;
  logic        io_only = 1'b0;
  logic        done, crc_err, frame_err;
  logic [5:0]  index;
  logic [31:0] argument;
  logic [15:0] rca;
  logic        st_com_crc, st_illegal, st_error, st_ready, st_app_cmd, st_ake_err;
  logic [3:0]  st_state;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  sd_resp_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cmd_in(cmd_in), .io_only(io_only),
    .done(done), .crc_err(crc_err), .frame_err(frame_err), .index(index),
    .argument(argument), .rca(rca), .st_com_crc(st_com_crc), .st_illegal(st_illegal),
    .st_error(st_error), .st_state(st_state), .st_ready(st_ready),
    .st_app_cmd(st_app_cmd), .st_ake_err(st_ake_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Remainder of (data * x^7) divided by x^7+x^3+1, by long division
  function automatic logic [6:0] crc_div(input logic [39:0] d);
    logic [46:0] v;
    v = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v = v ^ (47'h89 << (i - 7));
    return v[6:0];
  endfunction

  function automatic logic [47:0] mk(input logic dir, input logic [5:0] idx,
                                     input logic [31:0] arg, input logic endb);
    logic [39:0] hd;
    hd = {1'b0, dir, idx, arg};
    return {hd, crc_div(hd), endb};
  endfunction

  function automatic logic [26:0] exp_stat(input logic [5:0] idx, input logic [31:0] a, input logic io);
    if (idx != 6'd3) return '0;
    return {a[31:16], a[15], a[14], a[13], io ? 4'd0 : a[12:9],
            io ? 1'b0 : a[8], io ? 1'b0 : a[5], io ? 1'b0 : a[3]};
  endfunction

  function automatic logic [26:0] act_stat();
    return {rca, st_com_crc, st_illegal, st_error, st_state, st_ready, st_app_cmd, st_ake_err};
  endfunction

  task automatic next_arg();
    seed = seed * 32'd1103515245 + 32'd12345;
  endtask

  // One strobe per bit, with an inverted level in the gap cycle (R10)
  task automatic send(input logic [47:0] f);
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk);
      cmd_in = f[i];
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      cmd_in = ~f[i];
      if (i == 1) chk(done == 1'b0, "R2 early done", done, 0);
    end
  endtask

  task automatic run(input logic [47:0] f, input logic io, input logic ecrc, input logic efrm);
    logic [5:0]  ei;
    logic [31:0] ea;
    logic [26:0] es;
    string       stag;
    ei = f[45:40];
    ea = f[39:8];
    es = exp_stat(ei, ea, io);
    stag = (ei == 6'd3) ? "R6 R7 status" : "R8 status";
    io_only = io;
    send(f);
    chk(done == 1'b1, "R2 done", done, 1);
    chk(index == ei, "R3 index", index, ei);
    chk(argument == ea, "R3 argument", argument, ea);
    chk(crc_err == ecrc, "R4 crc_err", crc_err, ecrc);
    chk(frame_err == efrm, "R5 frame_err", frame_err, efrm);
    chk(act_stat() == es, stag, act_stat(), es);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", done, 0);
    chk(argument == ea && index == ei, "R11 hold", argument, ea);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(done == 0 && crc_err == 0 && frame_err == 0, "R9 flags", {done, crc_err, frame_err}, 0);
    chk(index == 0 && argument == 0 && act_stat() == 0, "R9 fields", argument, 0);

    // R1: idle high strobes are ignored
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); cmd_in = 1'b1; bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0; cmd_in = 1'b0;
    end
    chk(done == 1'b0, "R1 idle no done", done, 0);
    run(mk(1'b0, 6'd17, 32'hA5C3_0F96, 1'b1), 1'b0, 1'b0, 1'b0); // R1 alignment

    // Sweep every index in both status modes
    for (int m = 0; m < 2; m++)
      for (int ix = 0; ix < 64; ix++) begin
        next_arg();
        run(mk(1'b0, 6'(ix), seed, 1'b1), 1'(m), 1'b0, 1'b0);
      end

    // Address-publication corner patterns
    run(mk(1'b0, 6'd3, 32'hFFFF_FFFF, 1'b1), 1'b0, 1'b0, 1'b0);
    run(mk(1'b0, 6'd3, 32'hFFFF_FFFF, 1'b1), 1'b1, 1'b0, 1'b0);
    run(mk(1'b0, 6'd3, 32'h0000_1FFF, 1'b1), 1'b1, 1'b0, 1'b0);
    run(mk(1'b0, 6'd3, 32'h1234_E000, 1'b1), 1'b0, 1'b0, 1'b0);
    run(mk(1'b0, 6'd0, 32'h0000_0000, 1'b1), 1'b0, 1'b0, 1'b0);

    // R4: each CRC bit flipped, then one payload bit
    for (int b = 1; b <= 7; b++) begin
      f = mk(1'b0, 6'd3, 32'hBEEF_2A5B, 1'b1);
      f[b] = ~f[b];
      run(f, 1'b0, 1'b1, 1'b0);
    end
    f = mk(1'b0, 6'd9, 32'h0000_0001, 1'b1);
    f[8] = ~f[8];
    run(f, 1'b1, 1'b1, 1'b0);

    // R5: framing faults with a consistent CRC
    run(mk(1'b1, 6'd3, 32'h7777_8888, 1'b1), 1'b0, 1'b0, 1'b1);
    run(mk(1'b0, 6'd3, 32'h7777_8888, 1'b0), 1'b0, 1'b0, 1'b1);
    f = mk(1'b1, 6'd5, 32'h0101_0101, 1'b0);
    f[3] = ~f[3];
    run(f, 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule